// File: doc/BRIEF.md
# Transmit DMA Mailbox

This block is a one-direction mailbox that carries bytes from an external DMA writer to an on-chip processor. The DMA side pushes bytes one at a time into a small byte store. The processor reads the same store as a bank of 16-bit words, two bytes per word. Software starts a transaction by loading a transfer count, written as the number of bytes minus one. The count steps down once for each byte the mailbox accepts.

The byte accepted while the count is zero ends the transaction. The block then leaves the busy state and sets a sticky done status. That status drives an interrupt unless one of two masks blocks it: a global mask, or a mask for the transmit component alone. Bytes that arrive while no transaction is armed are dropped, and a sticky overrun status records them. A new count load clears both status bits and arms the next transaction. A status-clear pulse also clears them.

Top module: `tx_dma_mailbox`

## Requirements
- R1: After reset, busy_o, done_o, overrun_o and irq_o are 0, cnt_o is 0, and every word reads 0 on rd_data_o.
- R2: A cycle with cnt_load_i high sets, from the next cycle, cnt_o to cnt_value_i and busy_o to 1, clears done_o and overrun_o, and restarts byte placement at byte 0.
- R3: The k-th byte accepted since the last load (k from 0) goes to word k/2: the low half (bits 7:0) when k is even, the high half (bits 15:8) when k is odd. rd_data_o shows word rd_addr_i combinationally, from the cycle after the write.
- R4: A write accepted while cnt_o is nonzero lowers cnt_o by one in the next cycle, and busy_o stays 1.
- R5: A write accepted while cnt_o is 0 clears busy_o and sets done_o in the next cycle, so a load of value n accepts exactly n+1 bytes.
- R6: A write while busy_o is 0 changes neither the stored words nor cnt_o, and it sets overrun_o. This includes writes before the first load.
- R7: irq_o is 1 exactly when done_o is 1 and both irq_mask_all_i and irq_mask_tx_i are 0. irq_o is combinational in the masks.
- R8: stat_clr_i clears done_o and overrun_o in the next cycle. An event that sets a status bit in the same cycle takes priority over the clear.
- R9: A write in the same cycle as cnt_load_i is discarded. It stores nothing, does not decrement the count and does not flag overrun.
- R10: A load does not erase stored bytes. Bytes not rewritten in the new transaction keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_wr_i | input | 1 | DMA byte write strobe |
| dma_data_i | input | 8 | DMA byte |
| rd_addr_i | input | 3 | Processor word index |
| rd_data_o | output | 16 | Processor word read data |
| cnt_load_i | input | 1 | Load transfer count and arm |
| cnt_value_i | input | 4 | Bytes to transfer minus one |
| cnt_o | output | 4 | Transfers remaining |
| stat_clr_i | input | 1 | Clear done and overrun status |
| irq_mask_all_i | input | 1 | Global interrupt mask |
| irq_mask_tx_i | input | 1 | Transmit interrupt mask |
| busy_o | output | 1 | Transaction armed |
| done_o | output | 1 | Sticky completion status |
| overrun_o | output | 1 | Sticky ignored-write status |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: 16 bytes, 8-bit bytes and 16-bit words, which gives a 4-bit count and eight words. At that size every count value from 0 to 15 can be swept. Each sweep reads back all eight words, so both halves of every word, the full-length transaction and the one-byte transaction are all exercised. Leftover bytes from longer earlier transactions also show up in the readback, which covers R10. All four mask combinations, clear-versus-set collisions, load-with-write collisions and writes before the first load are driven directly.

// File: rtl/tx_mbox_pkg.sv
`timescale 1ns/1ps
package tx_mbox_pkg;
  typedef struct packed {
    logic done;
    logic overrun;
  } mbox_sts_t;
endpackage

// File: rtl/tx_mbox_ctrl.sv
`timescale 1ns/1ps
module tx_mbox_ctrl
  import tx_mbox_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic             we_o,
  output logic [CNT_W-1:0] wptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output mbox_sts_t        sts_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, wptr_q;
  mbox_sts_t        sts_q;
  logic             accept, reject;

  // load owns the cycle; a coincident write is dropped silently
  assign accept = wr_i & ~load_i & busy_q;
  assign reject = wr_i & ~load_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wptr_q <= '0;
      sts_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val_i;
      wptr_q <= '0;
      sts_q  <= '0;
    end else begin
      // clear first so a same-cycle set wins
      if (clr_i) sts_q <= '0;
      if (accept) begin
        wptr_q <= wptr_q + CNT_W'(1);
        if (cnt_q == '0) begin
          busy_q     <= 1'b0;
          sts_q.done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (reject) sts_q.overrun <= 1'b1;
    end
  end

  assign we_o   = accept;
  assign wptr_o = wptr_q;
  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign sts_o  = sts_q;
endmodule

// File: rtl/tx_mbox_store.sv
`timescale 1ns/1ps
module tx_mbox_store #(
  parameter int BYTES  = 16,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int WORDS  = BYTES / LANES,
  localparam int PTR_W  = $clog2(BYTES),
  localparam int RADR_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [RADR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[b] <= '0;
      else if (we_i && waddr_i == PTR_W'(b))    mem_q[b] <= wdata_i;
    end
  end

  // byte k sits in word k/LANES, lane k%LANES (lane 0 = low bits)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      rdata_o[l*BYTE_W +: BYTE_W] = mem_q[int'(raddr_i) * LANES + l];
    end
  end
endmodule

// File: rtl/tx_mbox_irq.sv
`timescale 1ns/1ps
module tx_mbox_irq
  import tx_mbox_pkg::*;
(
  input  mbox_sts_t sts_i,
  input  logic      mask_all_i,
  input  logic      mask_tx_i,
  output logic      irq_o
);
  assign irq_o = sts_i.done & ~mask_all_i & ~mask_tx_i;
endmodule

// File: rtl/tx_dma_mailbox.sv
`timescale 1ns/1ps
module tx_dma_mailbox
  import tx_mbox_pkg::*;
#(
  parameter int BYTES  = 16,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int WORDS  = BYTES / LANES,
  localparam int CNT_W  = $clog2(BYTES),
  localparam int RADR_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_wr_i,
  input  logic [BYTE_W-1:0] dma_data_i,
  input  logic [RADR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              cnt_load_i,
  input  logic [CNT_W-1:0]  cnt_value_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              stat_clr_i,
  input  logic              irq_mask_all_i,
  input  logic              irq_mask_tx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic             we;
  logic [CNT_W-1:0] wptr;
  mbox_sts_t        sts;

  tx_mbox_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (dma_wr_i),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_value_i),
    .clr_i      (stat_clr_i),
    .we_o       (we),
    .wptr_o     (wptr),
    .cnt_o      (cnt_o),
    .busy_o     (busy_o),
    .sts_o      (sts)
  );

  tx_mbox_store #(.BYTES(BYTES), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (wptr),
    .wdata_i (dma_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  tx_mbox_irq i_irq (
    .sts_i      (sts),
    .mask_all_i (irq_mask_all_i),
    .mask_tx_i  (irq_mask_tx_i),
    .irq_o      (irq_o)
  );

  assign done_o    = sts.done;
  assign overrun_o = sts.overrun;
endmodule

// File: rtl/tx_dma_mailbox_chk.sv
`timescale 1ns/1ps
module tx_dma_mailbox_chk #(
  parameter int BYTES  = 16,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int WORDS  = BYTES / LANES,
  localparam int CNT_W  = $clog2(BYTES),
  localparam int RADR_W = $clog2(WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dma_wr_i,
  input logic [BYTE_W-1:0] dma_data_i,
  input logic [RADR_W-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              cnt_load_i,
  input logic [CNT_W-1:0]  cnt_value_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              stat_clr_i,
  input logic              irq_mask_all_i,
  input logic              irq_mask_tx_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              overrun_o,
  input logic              irq_o
);
  AST_LOAD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> busy_o && !done_o && !overrun_o && cnt_o == $past(cnt_value_i)); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_wr_i && !cnt_load_i && busy_o && cnt_o != '0 |=>
      busy_o && cnt_o == $past(cnt_o) - CNT_W'(1)); // R4

  AST_LAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_wr_i && !cnt_load_i && busy_o && cnt_o == '0 |=> done_o && !busy_o); // R5

  AST_IDLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_wr_i && !cnt_load_i && !busy_o |=> overrun_o && $stable(cnt_o) && !busy_o); // R6

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (done_o && !irq_mask_all_i && !irq_mask_tx_i)); // R7

  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && !cnt_load_i && !dma_wr_i |=> !done_o && !overrun_o); // R8

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i && dma_wr_i |=> cnt_o == $past(cnt_value_i) && !overrun_o); // R9
endmodule

bind tx_dma_mailbox tx_dma_mailbox_chk #(
  .BYTES(BYTES), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dma_wr_i       (dma_wr_i),
  .dma_data_i     (dma_data_i),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .cnt_load_i     (cnt_load_i),
  .cnt_value_i    (cnt_value_i),
  .cnt_o          (cnt_o),
  .stat_clr_i     (stat_clr_i),
  .irq_mask_all_i (irq_mask_all_i),
  .irq_mask_tx_i  (irq_mask_tx_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .overrun_o      (overrun_o),
  .irq_o          (irq_o)
);

// File: tb/test_tx_dma_mailbox.sv
`timescale 1ns/1ps
module test_tx_dma_mailbox;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dma_wr_i = 1'b0;
  logic [7:0]  dma_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        cnt_load_i = 1'b0;
  logic [3:0]  cnt_value_i = '0;
  logic [3:0]  cnt_o;
  logic        stat_clr_i = 1'b0;
  logic        irq_mask_all_i = 1'b0;
  logic        irq_mask_tx_i = 1'b0;
  logic        busy_o, done_o, overrun_o, irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_mem [16];

  always #2.5 clk_i = ~clk_i;

  tx_dma_mailbox i_tx_dma_mailbox (
    .clk_i(clk_i), .rst_ni(rst_ni), .dma_wr_i(dma_wr_i), .dma_data_i(dma_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .cnt_load_i(cnt_load_i),
    .cnt_value_i(cnt_value_i), .cnt_o(cnt_o), .stat_clr_i(stat_clr_i),
    .irq_mask_all_i(irq_mask_all_i), .irq_mask_tx_i(irq_mask_tx_i),
    .busy_o(busy_o), .done_o(done_o), .overrun_o(overrun_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check_mem(input string req);
    for (int w = 0; w < 8; w++) begin
      rd_addr_i = 3'(w);
      #0.4;
      chk(req, 32'(rd_data_o), 32'({exp_mem[2*w+1], exp_mem[2*w]}));
    end
  endtask

  task automatic do_load(input logic [3:0] v);
    cnt_load_i = 1'b1; cnt_value_i = v;
    tick();
    cnt_load_i = 1'b0;
    chk("R2 cnt", 32'(cnt_o), 32'(v));
    chk("R2 busy", 32'(busy_o), 32'd1);
    chk("R2 sts", 32'({done_o, overrun_o}), 32'd0);
  endtask

  task automatic do_wr(input logic [7:0] d);
    dma_wr_i = 1'b1; dma_data_i = d;
    tick();
    dma_wr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    #12;
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 sts", 32'({done_o, overrun_o, irq_o}), 32'd0);
    chk("R1 cnt", 32'(cnt_o), 32'd0);
    check_mem("R1 mem");
    rst_ni = 1'b1;
    tick();

    // R6 write before first load
    do_wr(8'hC3);
    chk("R6 pre-load overrun", 32'(overrun_o), 32'd1);
    chk("R6 pre-load cnt", 32'(cnt_o), 32'd0);
    check_mem("R6 pre-load mem");

    // sweep every count value; R3/R4/R5/R10
    for (int n = 0; n < 16; n++) begin
      do_load(4'(n));
      for (int k = 0; k <= n; k++) begin
        logic [7:0] d;
        d = 8'(n * 37 + k * 11 + 3);
        do_wr(d);
        exp_mem[k] = d;
        if (k < n) begin
          chk("R4 cnt", 32'(cnt_o), 32'(n - k - 1));
          chk("R4 busy", 32'(busy_o), 32'd1);
        end else begin
          chk("R5 busy", 32'(busy_o), 32'd0);
          chk("R5 done", 32'(done_o), 32'd1);
          chk("R7 irq", 32'(irq_o), 32'd1);
        end
      end
      check_mem("R3 R10 mem");
      do_wr(8'hFF);
      chk("R6 overrun", 32'(overrun_o), 32'd1);
      chk("R6 cnt", 32'(cnt_o), 32'd0);
      check_mem("R6 mem");
      stat_clr_i = 1'b1;
      tick();
      stat_clr_i = 1'b0;
      chk("R8 clr", 32'({done_o, overrun_o, irq_o}), 32'd0);
    end

    // R7 mask combinations
    do_load(4'd0);
    do_wr(8'h11); exp_mem[0] = 8'h11;
    for (int m = 0; m < 4; m++) begin
      irq_mask_all_i = m[0]; irq_mask_tx_i = m[1];
      #0.4;
      chk("R7 mask", 32'(irq_o), 32'(m == 0));
    end
    irq_mask_all_i = 1'b0; irq_mask_tx_i = 1'b0;

    // R8 clear vs set collision: idle write sets overrun, clear drops done
    stat_clr_i = 1'b1; dma_wr_i = 1'b1; dma_data_i = 8'h77;
    tick();
    stat_clr_i = 1'b0; dma_wr_i = 1'b0;
    chk("R8 set wins", 32'(overrun_o), 32'd1);
    chk("R8 done cleared", 32'(done_o), 32'd0);

    // R8 clear vs completion collision
    do_load(4'd0);
    stat_clr_i = 1'b1; dma_wr_i = 1'b1; dma_data_i = 8'h5C;
    tick();
    stat_clr_i = 1'b0; dma_wr_i = 1'b0;
    exp_mem[0] = 8'h5C;
    chk("R8 done wins", 32'(done_o), 32'd1);

    // R9 load with write
    cnt_load_i = 1'b1; cnt_value_i = 4'd1; dma_wr_i = 1'b1; dma_data_i = 8'hAB;
    tick();
    cnt_load_i = 1'b0; dma_wr_i = 1'b0;
    chk("R9 cnt", 32'(cnt_o), 32'd1);
    chk("R9 overrun", 32'(overrun_o), 32'd0);
    check_mem("R9 mem");
    do_wr(8'h21); exp_mem[0] = 8'h21;
    do_wr(8'h43); exp_mem[1] = 8'h43;
    chk("R9 done", 32'(done_o), 32'd1);
    check_mem("R9 placement");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule